// File: doc/BRIEF.md
# SPI Host Transmit/Receive Queues with Watermark Interrupt

This block sits between a processor's register bus and the shift engine of an SPI host. Software writes outgoing frames into a transmit queue through a data register and reads incoming frames out of a receive queue through a second data register. Each data register reports the queue's blocking condition in bit 31: transmit full on one, receive empty on the other. Software can therefore poll a single word instead of a separate status register.

The shift engine sits outside the block. It drains the transmit queue through a pop strobe and fills the receive queue through a push strobe. Two watermark registers set level thresholds. Two pending bits follow the queue levels against those thresholds, and an enable register gates them onto one interrupt line. A typical transfer loads up to one queue depth of frames. Software then sets the receive threshold to the frame count minus one and waits for the receive pending bit, which shows that every frame has come back.

Top module: `spi_queue_regs`

## Requirements
- R1: After reset both queues are empty, the transmit threshold reads 1, the receive threshold reads 0, the enable register reads 0, the pending register reads 1 (only the transmit bit set) and `irq_o` is low.
- R2: A register write to offset 0x48 pushes `reg_wdata_i[7:0]` into the transmit queue, and the engine sees the frames on `tx_data_o` in the order they were written, advancing on each `tx_pop_i` pulse.
- R3: A register read of offset 0x48 returns bit 31 set exactly when the transmit queue holds DEPTH frames, with all other bits zero. A write to 0x48 while the queue is full is dropped.
- R4: A register read of offset 0x4c on a non-empty receive queue returns the oldest frame in bits [7:0] with bit 31 clear, and removes that frame.
- R5: A register read of offset 0x4c on an empty receive queue returns exactly 0x8000_0000 and removes nothing.
- R6: Pending bit 0 (offset 0x74) is 1 exactly when the transmit queue holds fewer frames than the threshold at offset 0x50.
- R7: Pending bit 1 (offset 0x74) is 1 exactly when the receive queue holds more frames than the threshold at offset 0x54.
- R8: `irq_o` is high exactly when some pending bit is set together with the matching bit of the enable register at offset 0x70 (bit 0 transmit, bit 1 receive). Writes to 0x74 have no effect.
- R9: The threshold registers at 0x50 and 0x54 and the enable register at 0x70 read back the value last written.
- R10: `tx_valid_o` is high exactly when the transmit queue is non-empty. `rx_ready_o` is high exactly when the receive queue is not full. An engine push while it is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe, one cycle per access |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the strobe |
| tx_pop_i | input | 1 | Engine takes the head of the transmit queue |
| tx_data_o | output | DW | Head of the transmit queue |
| tx_valid_o | output | 1 | Transmit queue non-empty |
| rx_push_i | input | 1 | Engine delivers a received frame |
| rx_data_i | input | DW | Received frame |
| rx_ready_o | output | 1 | Receive queue has room |
| irq_o | output | 1 | Masked watermark interrupt |

## Verification
The bench sweeps every threshold value from 0 to DEPTH for both queues. At each threshold it walks the queue level through every value from empty to full, so an off-by-one in the compare direction or in strictness shows up at exactly one level. Each fill uses frame values that depend on the threshold and the position, which separates ordering faults from stale data. A push at full is followed by a complete drain and an empty probe, which catches a dropped-write fault that would otherwise overwrite or add a frame. The interrupt is tried with all four enable patterns under both pending patterns.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam logic [7:0] OFF_TXDATA = 8'h48;
  localparam logic [7:0] OFF_RXDATA = 8'h4c;
  localparam logic [7:0] OFF_TXMARK = 8'h50;
  localparam logic [7:0] OFF_RXMARK = 8'h54;
  localparam logic [7:0] OFF_IEN    = 8'h70;
  localparam logic [7:0] OFF_IPEND  = 8'h74;

  localparam int unsigned IP_TX = 0;
  localparam int unsigned IP_RX = 1;
  localparam int unsigned NUM_IP = 2;

  localparam int unsigned FLAG_BIT = 31;
endpackage

// File: rtl/spiq_fifo.sv
module spiq_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));

  // R3
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_ptr_q)));

  // R5
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rd_ptr_q)));
endmodule

// File: rtl/spiq_wm.sv
module spiq_wm #(
  parameter int unsigned CW = 4
) (
  input  logic          [CW-1:0] tx_count_i,
  input  logic          [CW-1:0] rx_count_i,
  input  logic          [CW-1:0] tx_mark_i,
  input  logic          [CW-1:0] rx_mark_i,
  input  logic [spiq_pkg::NUM_IP-1:0] ien_i,
  output logic [spiq_pkg::NUM_IP-1:0] pend_o,
  output logic                        irq_o
);
  import spiq_pkg::*;

  always_comb begin
    pend_o        = '0;
    pend_o[IP_TX] = (tx_count_i < tx_mark_i);
    pend_o[IP_RX] = (rx_count_i > rx_mark_i);
  end

  assign irq_o = |(pend_o & ien_i);
endmodule

// File: rtl/spi_queue_regs.sv
module spi_queue_regs #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_req_i,
  input  logic          reg_we_i,
  input  logic [7:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_ready_o,
  output logic          irq_o
);
  import spiq_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          wr_acc, rd_acc;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_head;
  logic [CW-1:0] tx_mark_q, rx_mark_q;
  logic [NUM_IP-1:0] ien_q, pend;
  logic          tx_push, rx_pop;

  assign wr_acc  = reg_req_i && reg_we_i;
  assign rd_acc  = reg_req_i && !reg_we_i;
  assign tx_push = wr_acc && (reg_addr_i == OFF_TXDATA);
  assign rx_pop  = rd_acc && (reg_addr_i == OFF_RXDATA);

  spiq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i (tx_push),
    .wdata_i(reg_wdata_i[DW-1:0]),
    .pop_i  (tx_pop_i),
    .rdata_o(tx_data_o),
    .full_o (tx_full),
    .empty_o(tx_empty),
    .count_o(tx_cnt)
  );

  spiq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i (rx_push_i),
    .wdata_i(rx_data_i),
    .pop_i  (rx_pop),
    .rdata_o(rx_head),
    .full_o (rx_full),
    .empty_o(rx_empty),
    .count_o(rx_cnt)
  );

  assign tx_valid_o = !tx_empty;
  assign rx_ready_o = !rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_mark_q <= CW'(1);
      rx_mark_q <= '0;
      ien_q     <= '0;
    end else if (wr_acc) begin
      unique case (reg_addr_i)
        OFF_TXMARK: tx_mark_q <= reg_wdata_i[CW-1:0];
        OFF_RXMARK: rx_mark_q <= reg_wdata_i[CW-1:0];
        OFF_IEN:    ien_q     <= reg_wdata_i[NUM_IP-1:0];
        default: ;
      endcase
    end
  end

  spiq_wm #(.CW(CW)) u_wm (
    .tx_count_i(tx_cnt),
    .rx_count_i(rx_cnt),
    .tx_mark_i (tx_mark_q),
    .rx_mark_i (rx_mark_q),
    .ien_i     (ien_q),
    .pend_o    (pend),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_TXDATA: reg_rdata_o[FLAG_BIT] = tx_full;
      OFF_RXDATA: begin
        reg_rdata_o[FLAG_BIT] = rx_empty;
        if (!rx_empty) reg_rdata_o[DW-1:0] = rx_head;
      end
      OFF_TXMARK: reg_rdata_o = 32'(tx_mark_q);
      OFF_RXMARK: reg_rdata_o = 32'(rx_mark_q);
      OFF_IEN:    reg_rdata_o = 32'(ien_q);
      OFF_IPEND:  reg_rdata_o = 32'(pend);
      default: ;
    endcase
  end

  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);

  // R10
  rx_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ready_o && rx_push_i && !rx_pop) |=> !rx_ready_o);

  // R2
  tx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push && !tx_full && !tx_pop_i) |=> tx_valid_o);
endmodule

// File: tb/spi_queue_regs_test.sv
`timescale 1ns/1ps
module spi_queue_regs_test;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        tx_pop = 1'b0, tx_valid, rx_push = 1'b0, rx_ready, irq;
  logic [7:0]  tx_data, rx_data = '0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_queue_regs #(.DW(8), .DEPTH(D)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .tx_pop_i(tx_pop), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .irq_o(irq)
  );

  function automatic logic [7:0] pat(input int m, input int i);
    return 8'((m * 37 + i * 5 + 1) & 8'hFF);
  endfunction

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req_tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] d);
    @(negedge clk);
    rx_push = 1'b1; rx_data = d;
    @(posedge clk); #1;
    rx_push = 1'b0;
  endtask

  task automatic eng_pop(input logic [7:0] exp);
    @(negedge clk);
    chk("R2 tx head", 32'(tx_data), 32'(exp));
    tx_pop = 1'b1;
    @(posedge clk); #1;
    tx_pop = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    #12 rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    reg_rd(8'h74, r); chk("R1 pend", r, 32'h1);
    reg_rd(8'h70, r); chk("R1 ien", r, 32'h0);
    reg_rd(8'h50, r); chk("R1 txmark", r, 32'h1);
    reg_rd(8'h54, r); chk("R1 rxmark", r, 32'h0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 rx_ready", 32'(rx_ready), 1);
    reg_rd(8'h4c, r); chk("R5 empty read", r, 32'h8000_0000);

    // receive side sweep
    for (int m = 0; m <= D; m++) begin
      reg_wr(8'h54, 32'(m));
      reg_rd(8'h54, r); chk("R9 rxmark", r, 32'(m));
      for (int lvl = 0; lvl <= D; lvl++) begin
        reg_rd(8'h74, r);
        chk("R7 rx pend", 32'(r[1]), 32'(lvl > m));
        if (lvl < D) eng_push(pat(m, lvl));
      end
      @(negedge clk);
      chk("R10 rx_ready full", 32'(rx_ready), 0);
      eng_push(8'hEE);
      for (int i = 0; i < D; i++) begin
        reg_rd(8'h4c, r); chk("R4 rx pop", r, 32'(pat(m, i)));
      end
      reg_rd(8'h4c, r); chk("R5 drained", r, 32'h8000_0000);
      reg_rd(8'h4c, r); chk("R5 repeat empty", r, 32'h8000_0000);
    end

    // transmit side sweep
    for (int m = 0; m <= D; m++) begin
      reg_wr(8'h50, 32'(m));
      reg_rd(8'h50, r); chk("R9 txmark", r, 32'(m));
      for (int lvl = 0; lvl <= D; lvl++) begin
        reg_rd(8'h74, r);
        chk("R6 tx pend", 32'(r[0]), 32'(lvl < m));
        reg_rd(8'h48, r);
        chk("R3 tx full flag", r, (lvl == D) ? 32'h8000_0000 : 32'h0);
        if (lvl < D) reg_wr(8'h48, 32'(pat(m + 20, lvl)));
      end
      reg_wr(8'h48, 32'hEE);
      for (int i = 0; i < D; i++) begin
        @(negedge clk);
        chk("R10 tx_valid", 32'(tx_valid), 1);
        eng_pop(pat(m + 20, i));
      end
      @(negedge clk);
      chk("R3 R10 drop at full", 32'(tx_valid), 0);
    end

    // interrupt masking: tx pend=1 (0 < 8), rx pend=0 (rxmark=8)
    for (int e = 0; e < 4; e++) begin
      reg_wr(8'h70, 32'(e));
      reg_rd(8'h70, r); chk("R9 ien", r, 32'(e));
      chk("R8 irq tx only", 32'(irq), 32'((e & 1) != 0));
    end
    reg_wr(8'h54, 32'h0);
    eng_push(8'h5A);
    for (int e = 0; e < 4; e++) begin
      reg_wr(8'h70, 32'(e));
      chk("R8 irq both", 32'(irq), 32'(e != 0));
    end
    reg_wr(8'h74, 32'h0);
    reg_rd(8'h74, r); chk("R8 pend read-only", r, 32'h3);
    reg_wr(8'h70, 32'h2);
    reg_wr(8'h50, 32'h0);
    chk("R8 rx only enabled", 32'(irq), 1);
    reg_rd(8'h4c, r); chk("R4 last frame", r, 32'h5A);
    @(negedge clk);
    chk("R8 irq cleared", 32'(irq), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule